// File: doc/BRIEF.md
# Dual TAP Handoff Controller

This block is a primary test access port controller in the IEEE 1149.1 style. It runs the sixteen-state TAP state machine, a 4-bit instruction register, a 32-bit identification register and a one-bit bypass register. It also owns the decision to hand the test port over to a second, lower-level debug TAP. That second TAP is outside this block. It appears here only as a serial data input, which the block routes to TDO once the handoff has happened.

Control can pass to the debug TAP by two routes. In the first, the primary TAP sits in Test-Logic-Reset and the active-low debug event input is sampled low on two consecutive rising test-clock edges. In the second, the ENABLE instruction is loaded through Update-IR. The handoff cannot be undone by the test port itself. After it, the primary TAP ignores TMS, and TDO and its enable follow the debug TAP. Only an active-low `trst_n` returns ownership to the primary TAP. `trst_n` also stands in for power-on reset.

Top module: `dual_tap_handoff`

## Requirements
- R1: While `trst_n` is low, the block holds Test-Logic-Reset asynchronously. `low_tap_en`, `tdo_sel_low`, `tdo_oe` and `tdo` are all 0, and the active instruction is IDCODE (0x2).
- R2: The state machine follows the standard sixteen-state TMS transition graph on rising `tck`. This includes the Pause/Exit2 loops. Five rising edges with TMS=1 reach Test-Logic-Reset from any state.
- R3: With IDCODE (0x2) active, Capture-DR loads the 32-bit identification value, whose bit 0 is 1. Shift-DR presents it least significant bit first.
- R4: With BYPASS (0xF), or with any code other than 0x2 and 0x3, a one-bit register sits between TDI and TDO. It is cleared in Capture-DR, so TDO shows 0 first and then TDI delayed by one shift.
- R5: Capture-IR loads 0b0001. Shift-IR presents it least significant bit first, while TDI enters at the most significant end. The new code takes effect on leaving Update-IR.
- R6: TMS, TDI and the debug event are sampled on rising `tck`, and `tdo`/`tdo_oe` change on falling `tck`. Before the handoff, `tdo_oe` is 1 only in Shift-IR or Shift-DR. Otherwise `tdo` is 0.
- R7: If `dbg_evt_n` is sampled low on two consecutive rising edges while the primary TAP is in Test-Logic-Reset, `low_tap_en` rises at the second of those edges.
- R8: The debug-event count starts over when `dbg_evt_n` is sampled high, and also on any edge where the primary TAP is not in Test-Logic-Reset. A single low sample, or low samples outside Test-Logic-Reset, do not hand over.
- R9: Leaving Update-IR with 0x3 in the instruction shift register sets `low_tap_en` at that edge.
- R10: After the handoff, `low_tap_en` and `tdo_sel_low` stay 1, `tdo_oe` is 1, and `tdo` equals `low_tdo`. TMS, TDI and `dbg_evt_n` have no further effect.
- R11: Driving `trst_n` low after a handoff returns ownership to the primary TAP. IDCODE can then be read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset (also models power-on) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| dbg_evt_n | input | 1 | Active-low debug event request |
| low_tdo | input | 1 | Serial data out of the lower-level debug TAP |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for `tdo` |
| low_tap_en | output | 1 | Enable for the lower-level debug TAP |
| tdo_sel_low | output | 1 | TDO source select: 1 selects the debug TAP |

## Verification
The assertions assume the following about the inputs:
- `trst_n` is pulsed low before first use, because the block has no internal power-on circuit.
- TMS, TDI and `dbg_evt_n` are stable around each rising `tck`.
- `low_tdo` is only meaningful after the handoff.

The stimulus meets these assumptions as follows. It changes every input one nanosecond after a falling edge, so the next rising edge falls mid-cycle. It opens each scenario, and the run, with a `trst_n` pulse. It checks every cycle against a behavioural model that tracks the TAP state as an integer and the scan registers as bit queues.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET   = 4'd0,
      ST_IDLE    = 4'd1,
      ST_SEL_DR  = 4'd2,
      ST_CAP_DR  = 4'd3,
      ST_SH_DR   = 4'd4,
      ST_EX1_DR  = 4'd5,
      ST_PS_DR   = 4'd6,
      ST_EX2_DR  = 4'd7,
      ST_UPD_DR  = 4'd8,
      ST_SEL_IR  = 4'd9,
      ST_CAP_IR  = 4'd10,
      ST_SH_IR   = 4'd11,
      ST_EX1_IR  = 4'd12,
      ST_PS_IR   = 4'd13,
      ST_EX2_IR  = 4'd14,
      ST_UPD_IR  = 4'd15
   } tap_state_e;

   function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
      tap_state_e n;
      unique case (cur)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PS_DR;
         ST_PS_DR:  n = m ? ST_EX2_DR : ST_PS_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PS_IR;
         ST_PS_IR:  n = m ? ST_EX2_IR : ST_PS_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         default:   n = m ? ST_SEL_DR : ST_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   input  logic       run,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         state <= ST_RESET;
      else if (run)
         state <= tap_next(state, tms);
   end

   // R2
   reset_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (run && state == ST_RESET && tms) |=> (state == ST_RESET));

   // R2
   shift_dr_stay_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (run && state == ST_SH_DR && !tms) |=> (state == ST_SH_DR));

   // R10
   frozen_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !run |=> $stable(state));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int unsigned          IR_W      = 4,
   parameter logic [IR_W-1:0]      OP_IDCODE = 'h2
)(
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  logic            run,
   input  tap_state_e      state,
   output logic [IR_W-1:0] instr,
   output logic [IR_W-1:0] shadow,
   output logic            upd_stb,
   output logic            ir_so
);

   localparam logic [IR_W-1:0] IR_CAP = {{(IR_W-2){1'b0}}, 2'b01};

   logic [IR_W-1:0] sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr    <= IR_CAP;
         instr <= OP_IDCODE;
      end else if (run) begin
         case (state)
            ST_CAP_IR: sr    <= IR_CAP;
            ST_SH_IR:  sr    <= {tdi, sr[IR_W-1:1]};
            ST_UPD_IR: instr <= sr;
            ST_RESET:  instr <= OP_IDCODE;
            default:   ;
         endcase
      end
   end

   assign shadow  = sr;
   assign upd_stb = run && (state == ST_UPD_IR);
   assign ir_so   = sr[0];

   // R5
   ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (run && state == ST_CAP_IR) |=> (sr == IR_CAP));

   // R1
   ir_reset_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (run && state == ST_RESET) |=> (instr == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int unsigned        ID_W     = 32,
   parameter logic [ID_W-1:0]    ID_VALUE = 32'h1A5C_E02F
)(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tdi,
   input  logic       run,
   input  logic       sel_id,
   input  tap_state_e state,
   output logic       dr_so
);

   logic [ID_W-1:0] id_sr;
   logic            byp;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_sr <= ID_VALUE;
         byp   <= 1'b0;
      end else if (run) begin
         if (state == ST_CAP_DR) begin
            if (sel_id) id_sr <= ID_VALUE;
            else        byp   <= 1'b0;
         end else if (state == ST_SH_DR) begin
            if (sel_id) id_sr <= {tdi, id_sr[ID_W-1:1]};
            else        byp   <= tdi;
         end
      end
   end

   assign dr_so = sel_id ? id_sr[0] : byp;

   // R4
   bypass_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (run && state == ST_CAP_DR && !sel_id) |=> (byp == 1'b0));

   // R3
   id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (run && state == ST_CAP_DR && sel_id) |=> (dr_so == 1'b1));

endmodule

// File: rtl/tap_handoff.sv
module tap_handoff #(
   parameter int unsigned     IR_W      = 4,
   parameter logic [IR_W-1:0] OP_ENABLE = 'h3,
   parameter int unsigned     DE_CYCLES = 2
)(
   input  logic            tck,
   input  logic            trst_n,
   input  logic            in_reset_st,
   input  logic            dbg_evt_n,
   input  logic            ir_upd,
   input  logic [IR_W-1:0] ir_shadow,
   output logic            handed
);

   logic de_hit;
   logic ir_hit;
   logic qual;

   assign qual   = in_reset_st && !dbg_evt_n && !handed;
   assign ir_hit = ir_upd && (ir_shadow == OP_ENABLE);

   generate
      if (DE_CYCLES == 1) begin : g_de_direct
         assign de_hit = qual;
      end else begin : g_de_count
         localparam int unsigned CW = $clog2(DE_CYCLES + 1);
         localparam logic [CW-1:0] LAST = CW'(DE_CYCLES - 1);
         logic [CW-1:0] cnt;

         assign de_hit = qual && (cnt == LAST);

         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)
               cnt <= '0;
            else if (!qual)
               cnt <= '0;
            else if (!de_hit)
               cnt <= cnt + CW'(1);
         end

         // R8
         count_restart_chk: assert property (@(posedge tck) disable iff (!trst_n)
            (!in_reset_st || dbg_evt_n) |=> (cnt == '0));
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         handed <= 1'b0;
      else if (de_hit || ir_hit)
         handed <= 1'b1;
   end

   // R10
   handoff_sticky_chk: assert property (@(posedge tck) disable iff (!trst_n)
      handed |=> handed);

   // R7 R9
   handoff_cause_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(handed) |-> ($past(in_reset_st && !dbg_evt_n) || $past(ir_upd)));

   // R9
   ir_route_chk: assert property (@(posedge tck) disable iff (!trst_n)
      ir_hit |=> handed);

endmodule

// File: rtl/dual_tap_handoff.sv
module dual_tap_handoff
   import tap_pkg::*;
#(
   parameter int unsigned     IR_W      = 4,
   parameter int unsigned     ID_W      = 32,
   parameter logic [ID_W-1:0] ID_VALUE  = 32'h1A5C_E02F,
   parameter logic [IR_W-1:0] OP_IDCODE = 'h2,
   parameter logic [IR_W-1:0] OP_ENABLE = 'h3,
   parameter int unsigned     DE_CYCLES = 2
)(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   input  logic dbg_evt_n,
   input  logic low_tdo,
   output logic tdo,
   output logic tdo_oe,
   output logic low_tap_en,
   output logic tdo_sel_low
);

   localparam logic [IR_W-1:0] OP_BYPASS = '1;

   initial begin
      idcode_lsb_chk: assert (ID_VALUE[0] == 1'b1)
         else $error("identification value must have bit 0 set");
      ir_width_chk: assert (IR_W >= 2)
         else $error("instruction register needs at least two bits");
      opcode_clash_chk: assert (OP_IDCODE != OP_ENABLE && OP_IDCODE != OP_BYPASS
                                && OP_ENABLE != OP_BYPASS)
         else $error("instruction codes must be distinct");
      de_cycles_chk: assert (DE_CYCLES >= 1)
         else $error("debug event count must be at least one");
   end

   tap_state_e      state;
   logic            handed;
   logic            run;
   logic [IR_W-1:0] instr;
   logic [IR_W-1:0] ir_shadow;
   logic            ir_upd;
   logic            ir_so;
   logic            dr_so;
   logic            tdo_q;
   logic            oe_q;

   assign run = !handed;

   tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .run    (run),
      .state  (state)
   );

   tap_ir #(
      .IR_W      (IR_W),
      .OP_IDCODE (OP_IDCODE)
   ) u_ir (
      .tck     (tck),
      .trst_n  (trst_n),
      .tdi     (tdi),
      .run     (run),
      .state   (state),
      .instr   (instr),
      .shadow  (ir_shadow),
      .upd_stb (ir_upd),
      .ir_so   (ir_so)
   );

   tap_dr #(
      .ID_W     (ID_W),
      .ID_VALUE (ID_VALUE)
   ) u_dr (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .run    (run),
      .sel_id (instr == OP_IDCODE),
      .state  (state),
      .dr_so  (dr_so)
   );

   tap_handoff #(
      .IR_W      (IR_W),
      .OP_ENABLE (OP_ENABLE),
      .DE_CYCLES (DE_CYCLES)
   ) u_handoff (
      .tck         (tck),
      .trst_n      (trst_n),
      .in_reset_st (state == ST_RESET),
      .dbg_evt_n   (dbg_evt_n),
      .ir_upd      (ir_upd),
      .ir_shadow   (ir_shadow),
      .handed      (handed)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         case (state)
            ST_SH_IR: begin tdo_q <= ir_so; oe_q <= 1'b1; end
            ST_SH_DR: begin tdo_q <= dr_so; oe_q <= 1'b1; end
            default:  begin tdo_q <= 1'b0;  oe_q <= 1'b0; end
         endcase
      end
   end

   assign tdo         = handed ? low_tdo : tdo_q;
   assign tdo_oe      = handed | oe_q;
   assign low_tap_en  = handed;
   assign tdo_sel_low = handed;

   // R6
   oe_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      oe_q |-> (state == ST_SH_IR || state == ST_SH_DR));

   // R6
   park_low_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!handed && !tdo_oe) |-> (tdo == 1'b0));

   // R10
   follow_low_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_sel_low |-> (tdo == low_tdo && tdo_oe));

endmodule

// File: tb/dual_tap_handoff_test.sv
module dual_tap_handoff_test;

   localparam logic [31:0] IDV = 32'h1A5C_E02F;
   localparam int IRW = 4;
   localparam int TLR = 0, RTI = 1, SDS = 2, CD = 3, SHD = 4, E1D = 5, PD = 6,
                  E2D = 7, UD = 8, SIS = 9, CI = 10, SHI = 11, E1I = 12,
                  PI = 13, E2I = 14, UI = 15;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1, tdi = 1'b0, dbg_evt_n = 1'b1, low_tdo = 1'b0;
   logic tdo, tdo_oe, low_tap_en, tdo_sel_low;

   int checks = 0;
   int errors = 0;

   // reference model
   int m_st;
   int m_ir;
   int m_cnt;
   bit m_en;
   bit m_tdo, m_oe;
   bit irq[$];
   bit drq[$];

   always #2 tck = ~tck;

   dual_tap_handoff #(.ID_VALUE(IDV)) uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .dbg_evt_n(dbg_evt_n), .low_tdo(low_tdo),
      .tdo(tdo), .tdo_oe(tdo_oe), .low_tap_en(low_tap_en),
      .tdo_sel_low(tdo_sel_low)
   );

   function automatic int nxt(int s, bit m);
      case (s)
         TLR: return m ? TLR : RTI;
         RTI: return m ? SDS : RTI;
         SDS: return m ? SIS : CD;
         CD:  return m ? E1D : SHD;
         SHD: return m ? E1D : SHD;
         E1D: return m ? UD  : PD;
         PD:  return m ? E2D : PD;
         E2D: return m ? UD  : SHD;
         UD:  return m ? SDS : RTI;
         SIS: return m ? TLR : CI;
         CI:  return m ? E1I : SHI;
         SHI: return m ? E1I : SHI;
         E1I: return m ? UI  : PI;
         PI:  return m ? E2I : PI;
         E2I: return m ? UI  : SHI;
         default: return m ? SDS : RTI;
      endcase
   endfunction

   task automatic model_reset();
      m_st = TLR; m_ir = 2; m_cnt = 0; m_en = 0; m_tdo = 0; m_oe = 0;
      irq.delete(); irq.push_back(1'b1);
      for (int i = 1; i < IRW; i++) irq.push_back(1'b0);
      drq.delete(); drq.push_back(1'b0);
   endtask

   task automatic compare(input string tag);
      bit e_tdo, e_oe;
      e_tdo = m_en ? low_tdo : m_tdo;
      e_oe  = m_en ? 1'b1 : m_oe;
      checks++;
      if (tdo !== e_tdo || tdo_oe !== e_oe || low_tap_en !== m_en || tdo_sel_low !== m_en) begin
         errors++;
         $display("FAIL %s: tdo,oe,en,sel = %b%b%b%b expected %b%b%b%b at %0t",
                  tag, tdo, tdo_oe, low_tap_en, tdo_sel_low, e_tdo, e_oe, m_en, m_en, $time);
      end
   endtask

   task automatic step(input bit t_ms, input bit t_di, input bit t_de, input bit t_lo,
                       input string tag);
      bit new_en;
      int v;
      tms = t_ms; tdi = t_di; dbg_evt_n = t_de; low_tdo = t_lo;
      @(posedge tck);
      new_en = m_en;
      if (!m_en) begin
         case (m_st)
            TLR: m_ir = 2;
            CI: begin
               irq.delete(); irq.push_back(1'b1);
               for (int i = 1; i < IRW; i++) irq.push_back(1'b0);
            end
            SHI: begin void'(irq.pop_front()); irq.push_back(t_di); end
            UI: begin
               v = 0;
               for (int i = 0; i < IRW; i++) v += int'(irq[i]) << i;
               m_ir = v;
               if (v == 3) new_en = 1;
            end
            CD: begin
               drq.delete();
               if (m_ir == 2) for (int i = 0; i < 32; i++) drq.push_back(IDV[i]);
               else drq.push_back(1'b0);
            end
            SHD: begin void'(drq.pop_front()); drq.push_back(t_di); end
            default: ;
         endcase
         if (m_st == TLR && !t_de) begin
            m_cnt++;
            if (m_cnt >= 2) new_en = 1;
         end else m_cnt = 0;
         m_st = nxt(m_st, t_ms);
      end
      m_en = new_en;
      @(negedge tck);
      if (m_st == SHI)      begin m_tdo = irq[0]; m_oe = 1; end
      else if (m_st == SHD) begin m_tdo = drq[0]; m_oe = 1; end
      else                  begin m_tdo = 0;      m_oe = 0; end
      #1;
      compare(tag);
   endtask

   task automatic do_reset(input string tag);
      trst_n = 1'b0;
      model_reset();
      @(posedge tck);
      @(negedge tck);
      #1;
      compare(tag);
      trst_n = 1'b1;
   endtask

   // from Run-Test/Idle back to Run-Test/Idle
   task automatic load_ir(input int val, input string tag);
      step(1, 0, 1, 0, "R6");
      step(1, 0, 1, 0, "R6");
      step(0, 0, 1, 0, "R6");
      step(0, 0, 1, 0, tag);
      for (int i = 0; i < IRW; i++)
         step(i == IRW - 1, val[i], 1, 0, tag);
      step(1, 0, 1, 0, tag);
      step(0, 0, 1, 1, tag);
   endtask

   task automatic shift_dr(input int n, input logic [63:0] pat, input string tag);
      step(1, 0, 1, 0, "R6");
      step(0, 0, 1, 0, "R6");
      step(0, 0, 1, 0, tag);
      for (int i = 0; i < n; i++)
         step(i == n - 1, pat[i], 1, 0, tag);
      step(1, 0, 1, 0, tag);
      step(0, 0, 1, 0, tag);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      #1;
      do_reset("R1");
      step(0, 0, 1, 0, "R2");                       // to Run-Test/Idle
      shift_dr(32, 64'h0000_0000_9C3B_7A11, "R3");  // identification readout
      load_ir(4'hF, "R5");                          // capture pattern visible
      shift_dr(8, 64'hB5, "R4");                    // bypass delay
      load_ir(4'h0, "R4");                          // unassigned code -> bypass
      shift_dr(6, 64'h2D, "R4");
      load_ir(4'h2, "R3");
      // pause loop through Exit2-DR back into Shift-DR
      step(1, 0, 1, 0, "R2"); step(0, 0, 1, 0, "R2"); step(0, 0, 1, 0, "R2");
      step(0, 1, 1, 0, "R2"); step(0, 0, 1, 0, "R2"); step(1, 1, 1, 0, "R2");
      step(0, 0, 1, 0, "R2"); step(0, 0, 1, 0, "R2"); step(1, 0, 1, 0, "R2");
      step(0, 0, 1, 0, "R2"); step(0, 1, 1, 0, "R2"); step(0, 1, 1, 0, "R2");
      step(1, 0, 1, 0, "R2"); step(1, 0, 1, 0, "R2");
      for (int i = 0; i < 5; i++) step(1, 0, 1, 0, "R2");  // to Test-Logic-Reset
      // R8: interrupted debug event requests
      step(1, 0, 0, 0, "R8"); step(1, 0, 1, 0, "R8");
      step(1, 0, 0, 0, "R8"); step(1, 0, 1, 0, "R8");
      step(0, 0, 0, 0, "R8");                       // counted, then leaves reset state
      step(0, 0, 0, 0, "R8"); step(0, 0, 0, 0, "R8");
      step(1, 0, 0, 0, "R8"); step(1, 0, 0, 0, "R8"); step(1, 0, 1, 0, "R8");
      step(1, 0, 0, 0, "R8"); step(1, 0, 1, 0, "R8");
      // R7: two consecutive low samples in Test-Logic-Reset
      step(1, 0, 0, 0, "R7");
      step(1, 1, 0, 1, "R7");
      // R10: port now belongs to the debug TAP
      for (int i = 0; i < 12; i++)
         step(i % 3 == 0, i % 2 == 1, i % 4 == 0, (i * 5) % 3 == 1, "R10");
      // R11: test reset returns ownership
      do_reset("R11");
      step(0, 0, 1, 0, "R11");
      shift_dr(32, 64'h0000_0000_0F0F_3C3C, "R11");
      // R9: instruction route
      load_ir(4'h3, "R9");
      for (int i = 0; i < 10; i++)
         step(i % 2 == 0, 1, i % 3 == 0, i % 2 == 1, "R10");
      do_reset("R1");
      step(0, 0, 1, 0, "R1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule